// File: doc/BRIEF.md
# Low-Power Watchdog Timer with Prescaler and Postscaler

This block is a watchdog timer that runs from a slow, free-running clock of nominally 31 kHz. The clock first passes through a prescaler with two ratios, chosen by one select bit. The prescaler output then drives a postscaler whose ratio is a power of two, chosen by a select field. When the cascade reaches its terminal count, the block either asks for a device reset or, if the device is sleeping or idle, sends a wake pulse. In both cases it sets a timeout flag. The flag stays set until software clears it.

Firmware keeps the timer from expiring by restarting it. Four separate restart sources exist: a software clear, entry to a power-save state, exit from a power-save state, and completion of a clock switch. A synchronous device reset also restarts the timer. When the block is disabled, both counters stay at zero and the block requests no oscillator. When it is enabled, it requests the oscillator.

Top module: `lp_watchdog`

## Requirements
- R1: The prescaler ratio is P = 2^PRE_SHORT_LOG2 when `pre_sel`=0 and P = 2^PRE_LONG_LOG2 when `pre_sel`=1. The defaults give 32 and 128.
- R2: The postscaler ratio is 2^N, where N is the value of `ps_sel`. Count the clock edge that samples a restart as edge 0. A timeout output goes high at edge P·2^N, on the clock edge after the terminal count.
- R3: After a timeout, both counters start again from zero. The next timeout comes P·2^N edges after the edge of the previous one.
- R4: Each of `sw_clr`, `pwrsave_enter`, `pwrsave_exit` and `clksw_done` restarts the count on its own. A restart in the terminal-count cycle suppresses that timeout.
- R5: The synchronous reset `rst` clears both counters, `timeout_flag`, `rst_req` and `wake_pulse`. Counting restarts from zero when `rst` is released.
- R6: A timeout raises `rst_req` for exactly one cycle when `in_low_power`=0, and `wake_pulse` for exactly one cycle when `in_low_power`=1. The two outputs are never high together.
- R7: `timeout_flag` goes high on the same edge as the timeout output and holds until `flag_clr`. If `flag_clr` arrives in the same cycle as a new terminal count, the flag ends up set.
- R8: While `en`=0, both counters stay at zero and neither timeout output asserts. When `en` rises, counting starts from zero. `osc_req` equals `en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-frequency watchdog clock |
| rst | input | 1 | Synchronous active-high device reset |
| en | input | 1 | Watchdog enable |
| pre_sel | input | 1 | Prescaler select: 0 short ratio, 1 long ratio |
| ps_sel | input | PS_SEL_W | Postscaler exponent N, ratio 2^N |
| sw_clr | input | 1 | Software restart command |
| pwrsave_enter | input | 1 | Pulse on entry to sleep or idle |
| pwrsave_exit | input | 1 | Pulse on exit from sleep or idle |
| clksw_done | input | 1 | Pulse on completion of a clock switch |
| in_low_power | input | 1 | High while the device sleeps or idles |
| flag_clr | input | 1 | Software clear of the timeout flag |
| osc_req | output | 1 | Request to run the watchdog oscillator |
| rst_req | output | 1 | One-cycle device reset request |
| wake_pulse | output | 1 | One-cycle wake-up request |
| timeout_flag | output | 1 | Sticky timeout indicator |

## Verification
The bench builds the block with PRE_SHORT_LOG2=2, PRE_LONG_LOG2=3 and PS_SEL_W=3. This gives prescaler ratios of 4 and 8 and postscaler ratios up to 128. With these values the longest period is 1024 cycles, so every postscaler setting and both prescaler ratios can be timed to the exact edge. The same structure at its defaults would need millions of cycles per timeout. The smaller values also make the one-cycle corner cases easy to reach: a restart that collides with the terminal count, and a flag clear that collides with a new timeout.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Control word shared by the counter stages.
    typedef struct packed {
        logic run;      // watchdog enabled
        logic restart;  // zero all counts this cycle
    } wdt_ctl_t;

    // What a timeout turns into.
    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_RESET = 2'd1,
        ACT_WAKE  = 2'd2
    } wdt_action_e;

    // Terminal value of a power-of-two divider: 2^sel - 1.
    function automatic logic [31:0] ratio_mask(input int unsigned sel);
        return (32'd1 << sel) - 32'd1;
    endfunction

endpackage

// File: rtl/wdt_restart_ctl.sv
module wdt_restart_ctl
    import wdt_pkg::*;
#(
    parameter int NUM_SRC = 4
) (
    input  logic               rst,
    input  logic               en,
    input  logic [NUM_SRC-1:0] clr_src,
    output wdt_ctl_t           ctl
);
    // Any restart source, the reset, or a disabled watchdog zeroes the counts.
    always_comb begin
        ctl.run     = en;
        ctl.restart = rst | ~en | (|clr_src);
    end
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
#(
    parameter int SHORT_LOG2 = 5,
    parameter int LONG_LOG2  = 7
) (
    input  logic     clk,
    input  logic     rst,
    input  wdt_ctl_t ctl,
    input  logic     pre_sel,
    output logic     tick
);
    localparam int CNT_W = (LONG_LOG2 > SHORT_LOG2) ? LONG_LOG2 : SHORT_LOG2;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    always_comb begin
        last = pre_sel ? CNT_W'(ratio_mask(LONG_LOG2)) : CNT_W'(ratio_mask(SHORT_LOG2));
        tick = ctl.run && !ctl.restart && (cnt >= last);
    end

    always_ff @(posedge clk) begin
        if (ctl.restart)
            cnt <= '0;
        else if (cnt >= last)
            cnt <= '0;
        else
            cnt <= cnt + CNT_W'(1);
    end

    AST_PRE_RESTART: assert property (@(posedge clk) disable iff (rst)
        ctl.restart |=> (cnt == '0)) else $error("prescaler not restarted"); // R4
    AST_PRE_HELD_OFF: assert property (@(posedge clk) disable iff (rst)
        !ctl.run |=> !tick) else $error("prescaler ticked while disabled"); // R8
endmodule

// File: rtl/wdt_postscaler.sv
module wdt_postscaler
    import wdt_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  wdt_ctl_t         ctl,
    input  logic             tick,
    input  logic [SEL_W-1:0] ps_sel,
    output logic             expire
);
    localparam int POST_W = (1 << SEL_W) - 1;

    logic [POST_W-1:0] cnt;
    logic [POST_W-1:0] last;

    always_comb begin
        last   = POST_W'(ratio_mask(int'(ps_sel)));
        expire = tick && (cnt >= last);
    end

    always_ff @(posedge clk) begin
        if (ctl.restart)
            cnt <= '0;
        else if (tick) begin
            if (cnt >= last)
                cnt <= '0;
            else
                cnt <= cnt + POST_W'(1);
        end
    end

    AST_POST_RESTART: assert property (@(posedge clk) disable iff (rst)
        ctl.restart |=> (cnt == '0)) else $error("postscaler not restarted"); // R4
    AST_POST_WRAP: assert property (@(posedge clk) disable iff (rst)
        expire |=> (cnt == '0)) else $error("postscaler did not wrap"); // R3
endmodule

// File: rtl/wdt_response.sv
module wdt_response
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic in_low_power,
    input  logic flag_clr,
    output logic rst_req,
    output logic wake_pulse,
    output logic timeout_flag
);
    wdt_action_e action;

    always_comb begin
        if (!expire)
            action = ACT_NONE;
        else if (in_low_power)
            action = ACT_WAKE;
        else
            action = ACT_RESET;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_req      <= 1'b0;
            wake_pulse   <= 1'b0;
            timeout_flag <= 1'b0;
        end else begin
            rst_req      <= (action == ACT_RESET);
            wake_pulse   <= (action == ACT_WAKE);
            // A new event wins over a simultaneous software clear.
            timeout_flag <= (action != ACT_NONE) | (timeout_flag & ~flag_clr);
        end
    end

    AST_RST_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req) else $error("reset request longer than one cycle"); // R6
    AST_WAKE_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |=> !wake_pulse) else $error("wake pulse longer than one cycle"); // R6
    AST_OUT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(rst_req && wake_pulse)) else $error("reset and wake together"); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (timeout_flag && !flag_clr) |=> timeout_flag) else $error("flag dropped without clear"); // R7
    AST_FLAG_ON_EVENT: assert property (@(posedge clk) disable iff (rst)
        (rst_req || wake_pulse) |-> timeout_flag) else $error("event without flag"); // R7
endmodule

// File: rtl/lp_watchdog.sv
module lp_watchdog
    import wdt_pkg::*;
#(
    parameter int PRE_SHORT_LOG2 = 5,
    parameter int PRE_LONG_LOG2  = 7,
    parameter int PS_SEL_W       = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                pre_sel,
    input  logic [PS_SEL_W-1:0] ps_sel,
    input  logic                sw_clr,
    input  logic                pwrsave_enter,
    input  logic                pwrsave_exit,
    input  logic                clksw_done,
    input  logic                in_low_power,
    input  logic                flag_clr,
    output logic                osc_req,
    output logic                rst_req,
    output logic                wake_pulse,
    output logic                timeout_flag
);
    localparam int NUM_SRC = 4;

    wdt_ctl_t ctl;
    logic     tick;
    logic     expire;

    assign osc_req = en;

    wdt_restart_ctl #(.NUM_SRC(NUM_SRC)) u_ctl (
        .rst     (rst),
        .en      (en),
        .clr_src ({clksw_done, pwrsave_exit, pwrsave_enter, sw_clr}),
        .ctl     (ctl)
    );

    wdt_prescaler #(.SHORT_LOG2(PRE_SHORT_LOG2), .LONG_LOG2(PRE_LONG_LOG2)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .pre_sel (pre_sel),
        .tick    (tick)
    );

    wdt_postscaler #(.SEL_W(PS_SEL_W)) u_post (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .tick   (tick),
        .ps_sel (ps_sel),
        .expire (expire)
    );

    wdt_response u_resp (
        .clk          (clk),
        .rst          (rst),
        .expire       (expire),
        .in_low_power (in_low_power),
        .flag_clr     (flag_clr),
        .rst_req      (rst_req),
        .wake_pulse   (wake_pulse),
        .timeout_flag (timeout_flag)
    );

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!rst_req && !wake_pulse)) else $error("output while disabled"); // R8
endmodule

// File: tb/lp_watchdog_test.sv
module lp_watchdog_test;
    localparam int PS_W = 3;

    logic clk = 1'b0;
    logic rst, en, pre_sel, sw_clr, pwrsave_enter, pwrsave_exit, clksw_done;
    logic in_low_power, flag_clr;
    logic [PS_W-1:0] ps_sel;
    logic osc_req, rst_req, wake_pulse, timeout_flag;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    lp_watchdog #(.PRE_SHORT_LOG2(2), .PRE_LONG_LOG2(3), .PS_SEL_W(PS_W)) uut (
        .clk(clk), .rst(rst), .en(en), .pre_sel(pre_sel), .ps_sel(ps_sel),
        .sw_clr(sw_clr), .pwrsave_enter(pwrsave_enter), .pwrsave_exit(pwrsave_exit),
        .clksw_done(clksw_done), .in_low_power(in_low_power), .flag_clr(flag_clr),
        .osc_req(osc_req), .rst_req(rst_req), .wake_pulse(wake_pulse),
        .timeout_flag(timeout_flag)
    );

    typedef struct packed {
        logic        pre;
        logic [2:0]  ps;
        logic        lp;
        logic [1:0]  src;
        logic [15:0] exp;
    } vec_t;

    // Expected period = P * 2^N with P = 4 (pre=0) or 8 (pre=1).
    localparam vec_t VECS [8] = '{
        '{1'b0, 3'd0, 1'b0, 2'd0, 16'd4},
        '{1'b1, 3'd0, 1'b0, 2'd1, 16'd8},
        '{1'b0, 3'd3, 1'b1, 2'd2, 16'd32},
        '{1'b1, 3'd5, 1'b0, 2'd3, 16'd256},
        '{1'b0, 3'd7, 1'b0, 2'd0, 16'd512},
        '{1'b1, 3'd7, 1'b1, 2'd1, 16'd1024},
        '{1'b0, 3'd1, 1'b1, 2'd3, 16'd8},
        '{1'b1, 3'd2, 1'b0, 2'd2, 16'd32}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wait_edges(input int k);
        for (int i = 0; i < k; i++) step();
    endtask

    // Pulse one restart source across exactly one sampling edge.
    task automatic restart(input logic [1:0] src);
        case (src)
            2'd0: sw_clr = 1'b1;
            2'd1: pwrsave_enter = 1'b1;
            2'd2: pwrsave_exit = 1'b1;
            default: clksw_done = 1'b1;
        endcase
        step();
        sw_clr = 1'b0; pwrsave_enter = 1'b0; pwrsave_exit = 1'b0; clksw_done = 1'b0;
    endtask

    // Edges until a timeout output is seen, the first edge counted as 1.
    task automatic measure(output int n);
        n = 0;
        for (int i = 0; i < 3000; i++) begin
            step();
            n++;
            if (rst_req || wake_pulse) return;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int n;
        rst = 1'b1; en = 1'b0; pre_sel = 1'b0; ps_sel = '0;
        sw_clr = 1'b0; pwrsave_enter = 1'b0; pwrsave_exit = 1'b0; clksw_done = 1'b0;
        in_low_power = 1'b0; flag_clr = 1'b0;
        wait_edges(3);
        // R5 reset state
        chk("R5 rst_req", rst_req, 0);
        chk("R5 wake_pulse", wake_pulse, 0);
        chk("R5 flag", timeout_flag, 0);
        rst = 1'b0;

        // R8 disabled: nothing for longer than the longest period
        n = 0;
        for (int i = 0; i < 1500; i++) begin
            step();
            if (rst_req || wake_pulse || timeout_flag) n++;
        end
        chk("R8 quiet while disabled", n, 0);
        chk("R8 osc_req off", osc_req, 0);
        en = 1'b1;
        #1;
        chk("R8 osc_req on", osc_req, 1);
        measure(n);
        chk("R8 count from zero on enable", n, 4);

        // Table walk: R1 R2 R4 R6 R7
        foreach (VECS[k]) begin
            pre_sel = VECS[k].pre;
            ps_sel = VECS[k].ps;
            in_low_power = VECS[k].lp;
            restart(VECS[k].src);
            measure(n);
            chk("R2 period (R1 ratio, R4 source)", n, int'(VECS[k].exp));
            chk("R6 reset request", rst_req, int'(!VECS[k].lp));
            chk("R6 wake pulse", wake_pulse, int'(VECS[k].lp));
            chk("R7 flag set", timeout_flag, 1);
            flag_clr = 1'b1;
            step();
            flag_clr = 1'b0;
            chk("R6 one-shot", int'(rst_req | wake_pulse), 0);
            chk("R7 flag cleared", timeout_flag, 0);
        end

        // R3 periodic restart
        pre_sel = 1'b0; ps_sel = 3'd2; in_low_power = 1'b0;
        restart(2'd0);
        measure(n);
        chk("R3 first period", n, 16);
        measure(n);
        chk("R3 second period", n, 16);

        // R4 restart in the terminal cycle suppresses the timeout
        restart(2'd0);
        wait_edges(15);
        sw_clr = 1'b1;
        step();
        sw_clr = 1'b0;
        chk("R4 suppressed timeout", int'(rst_req | wake_pulse), 0);
        measure(n);
        chk("R4 period after late restart", n, 16);

        // R7 flag clear collides with a new timeout
        restart(2'd3);
        wait_edges(15);
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
        chk("R7 timeout in collision", rst_req, 1);
        chk("R7 flag set despite clear", timeout_flag, 1);

        // R5 reset mid-count clears flag and restarts count
        wait_edges(5);
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk("R5 flag cleared by reset", timeout_flag, 0);
        measure(n);
        chk("R5 period after reset", n, 16);

        // R8 short disable restarts the count
        restart(2'd1);
        wait_edges(10);
        en = 1'b0;
        step();
        en = 1'b1;
        chk("R8 no output on disable", int'(rst_req | wake_pulse), 0);
        measure(n);
        chk("R8 period after re-enable", n, 16);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule